// File: doc/BRIEF.md
# ECC Error Reporting Register Block

This block is the software-visible face of a memory path protected by a single-error-correct, double-error-detect code. It holds the controls that turn checking and correction on, and the two controls that ask the encoder to corrupt words as they are stored. Injection works per write: a word written while an inject control is set is stored with one or two flipped bits. The error is only reported later, when that word is read back and the decoder flags it.

The decoder reports each error through single-cycle event inputs: a correctable error, an uncorrectable error or a dropped correction, together with the failing address. The block records these events in sticky status bits and in two saturating 4-bit counters, and keeps one address register shared by both error kinds. It drives a level interrupt that can be masked per event kind. A single write to the interrupt register clears every pending record and sets the enable in the same access.

Access is through a plain 32-bit register bus with a write strobe and a combinational read path selected by the address.

Top module: `ecc_err_csr`

## Requirements
- R1: The control register at offset 0x00 stores bit 10 (check enable), bit 11 (correction enable), bit 13 (single-bit inject) and bit 14 (double-bit inject), and drives them on eccEnable, corrEnable, injSbe and injDbe. All its other bits read as zero, so writing all ones reads back 0x00006C00.
- R2: With checking enabled, a correctable, uncorrectable or dropped-correction event sets status bit 2, 3 or 4 of offset 0x38. Each bit stays set until a clear.
- R3: The correctable count at 0x40 and the uncorrectable count at 0x44 each go up by one per accepted event, in bits 3:0. They stop at 15 and do not wrap.
- R4: Offset 0x48 takes evtAddr on every accepted correctable or uncorrectable event, including both in one cycle. It holds its value otherwise; a dropped correction alone leaves it unchanged.
- R5: At offset 0x3C, bit 0 is the interrupt enable and bits 1, 2 and 3 mask (1 = masked) correctable, uncorrectable and dropped events. These bits read back and bit 4 reads 0. irq is high exactly when the enable is set and some status bit is set whose mask bit is clear.
- R6: Writing bit 4 of 0x3C as 1 clears all status bits and both counts, and the same write loads the enable and masks. Clear together with enable leaves the interrupt enabled; clear alone leaves it disabled.
- R7: An event accepted in the same cycle as a clear survives it: its status bit is set and its count reads 1.
- R8: While control bit 10 is 0, event inputs change no status bit, count or address.
- R9: Offset 0x30 reads the protected interface width, data width plus check width: 40 by default, 24 for 16-bit data.
- R10: Reads of unmapped offsets return zero. Writes to 0x30, 0x38, 0x40, 0x44 and 0x48 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| evtSbe | input | 1 | Decoder: correctable error this cycle |
| evtDbe | input | 1 | Decoder: uncorrectable error this cycle |
| evtDrop | input | 1 | Decoder: correction write-back dropped |
| evtAddr | input | EA_W | Decoder: address of the faulting access |
| eccEnable | output | 1 | Checking enabled |
| corrEnable | output | 1 | Correction enabled |
| injSbe | output | 1 | Encoder: corrupt one bit of written words |
| injDbe | output | 1 | Encoder: corrupt two bits of written words |
| irq | output | 1 | Level interrupt |

## Verification
A clear write to the interrupt register and a decoder event can land on the same clock edge. The outcome chosen is that the event is applied after the clear, so it is not lost. The bench provokes this with a directed write that carries the clear bit alongside a correctable event, and again in a random phase that mixes clear writes with random events. Each time it compares status, counts and irq against a model that applies the clear first and the event second.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  localparam int BUS_W = 32;

  // register offsets
  localparam logic [7:0] OFF_CTL    = 8'h00;
  localparam logic [7:0] OFF_WIDTH  = 8'h30;
  localparam logic [7:0] OFF_STAT   = 8'h38;
  localparam logic [7:0] OFF_INT    = 8'h3C;
  localparam logic [7:0] OFF_SBECNT = 8'h40;
  localparam logic [7:0] OFF_DBECNT = 8'h44;
  localparam logic [7:0] OFF_ADDR   = 8'h48;

  // control register fields
  localparam int CTL_ECC_BIT  = 10;
  localparam int CTL_CORR_BIT = 11;
  localparam int CTL_INJS_BIT = 13;
  localparam int CTL_INJD_BIT = 14;

  // status register: event kinds start at this bit
  localparam int STAT_LSB = 2;
  localparam int NUM_EVT  = 3;

  // interrupt register fields
  localparam int INT_EN_BIT   = 0;
  localparam int INT_MASK_LSB = 1;
  localparam int INT_CLR_BIT  = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_WIDTH, SEL_STAT,
    SEL_INT, SEL_SBECNT, SEL_DBECNT, SEL_ADDR
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrInt;
    logic   clrAll;
    rdSel_e rdSel;
  } csrStb_t;

endpackage

// File: rtl/ecc_err_ctrl.sv
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              clrBit,
  output csrStb_t           stb
);

  rdSel_e sel;

  always_comb begin
    if      (busAddr == ADDR_W'(OFF_CTL))    sel = SEL_CTL;
    else if (busAddr == ADDR_W'(OFF_WIDTH))  sel = SEL_WIDTH;
    else if (busAddr == ADDR_W'(OFF_STAT))   sel = SEL_STAT;
    else if (busAddr == ADDR_W'(OFF_INT))    sel = SEL_INT;
    else if (busAddr == ADDR_W'(OFF_SBECNT)) sel = SEL_SBECNT;
    else if (busAddr == ADDR_W'(OFF_DBECNT)) sel = SEL_DBECNT;
    else if (busAddr == ADDR_W'(OFF_ADDR))   sel = SEL_ADDR;
    else                                     sel = SEL_NONE;
  end

  always_comb begin
    stb.rdSel  = sel;
    stb.wrCtl  = busWrEn && (sel == SEL_CTL);
    stb.wrInt  = busWrEn && (sel == SEL_INT);
    stb.clrAll = busWrEn && (sel == SEL_INT) && clrBit;
  end

endmodule

// File: rtl/ecc_err_dp.sv
module ecc_err_dp
  import ecc_err_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 4,
  parameter int EA_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  csrStb_t            stb,
  input  logic [BUS_W-1:0]   busWrData,
  input  logic               evtSbe,
  input  logic               evtDbe,
  input  logic               evtDrop,
  input  logic [EA_W-1:0]    evtAddr,
  output logic [BUS_W-1:0]   rdData,
  output logic               eccEnable,
  output logic               corrEnable,
  output logic               injSbe,
  output logic               injDbe,
  output logic               irq,
  output logic [NUM_EVT-1:0] statQ,
  output logic [CNT_W-1:0]   sbeCnt,
  output logic [CNT_W-1:0]   dbeCnt,
  output logic [EA_W-1:0]    errAddr
);

  localparam logic [BUS_W-1:0] WIDTH_VAL = BUS_W'(DATA_W + CHK_W);
  localparam int NUM_CNT = 2;

  logic                intEn;
  logic [NUM_EVT-1:0]  intMask;
  logic [NUM_EVT-1:0]  evtAcc;
  logic [CNT_W-1:0]    cntQ [NUM_CNT];

  // events only count while checking is enabled
  assign evtAcc = eccEnable ? {evtDrop, evtDbe, evtSbe} : '0;

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eccEnable  <= 1'b0;
      corrEnable <= 1'b0;
      injSbe     <= 1'b0;
      injDbe     <= 1'b0;
    end else if (stb.wrCtl) begin
      eccEnable  <= busWrData[CTL_ECC_BIT];
      corrEnable <= busWrData[CTL_CORR_BIT];
      injSbe     <= busWrData[CTL_INJS_BIT];
      injDbe     <= busWrData[CTL_INJD_BIT];
    end
  end

  // interrupt enable and masks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intEn   <= 1'b0;
      intMask <= '0;
    end else if (stb.wrInt) begin
      intEn   <= busWrData[INT_EN_BIT];
      intMask <= busWrData[INT_MASK_LSB +: NUM_EVT];
    end
  end

  // sticky status: clear first, then this cycle's events on top
  always_ff @(posedge clk) begin
    if (!rst_n) statQ <= '0;
    else        statQ <= (stb.clrAll ? '0 : statQ) | evtAcc;
  end

  // saturating counters, one per error kind
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cntQ[i] <= '0;
      else if (stb.clrAll)
        cntQ[i] <= evtAcc[i] ? CNT_W'(1) : '0;
      else if (evtAcc[i] && (cntQ[i] != '1))
        cntQ[i] <= cntQ[i] + CNT_W'(1);
    end
  end

  assign sbeCnt = cntQ[0];
  assign dbeCnt = cntQ[1];

  // one address register for both error kinds
  always_ff @(posedge clk) begin
    if (!rst_n)                    errAddr <= '0;
    else if (evtAcc[0] || evtAcc[1]) errAddr <= evtAddr;
  end

  assign irq = intEn && |(statQ & ~intMask);

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      SEL_CTL: begin
        rdData[CTL_ECC_BIT]  = eccEnable;
        rdData[CTL_CORR_BIT] = corrEnable;
        rdData[CTL_INJS_BIT] = injSbe;
        rdData[CTL_INJD_BIT] = injDbe;
      end
      SEL_WIDTH:  rdData = WIDTH_VAL;
      SEL_STAT:   rdData[STAT_LSB +: NUM_EVT] = statQ;
      SEL_INT: begin
        rdData[INT_EN_BIT]              = intEn;
        rdData[INT_MASK_LSB +: NUM_EVT] = intMask;
      end
      SEL_SBECNT: rdData = BUS_W'(sbeCnt);
      SEL_DBECNT: rdData = BUS_W'(dbeCnt);
      SEL_ADDR:   rdData = BUS_W'(errAddr);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/ecc_err_csr.sv
module ecc_err_csr
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 4,
  parameter int EA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              evtSbe,
  input  logic              evtDbe,
  input  logic              evtDrop,
  input  logic [EA_W-1:0]   evtAddr,
  output logic              eccEnable,
  output logic              corrEnable,
  output logic              injSbe,
  output logic              injDbe,
  output logic              irq
);

  csrStb_t            stb;
  logic [NUM_EVT-1:0] statQ;
  logic [CNT_W-1:0]   sbeCnt;
  logic [CNT_W-1:0]   dbeCnt;
  logic [EA_W-1:0]    errAddr;

  ecc_err_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .clrBit  (busWrData[INT_CLR_BIT]),
    .stb     (stb)
  );

  ecc_err_dp #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W), .EA_W(EA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .busWrData  (busWrData),
    .evtSbe     (evtSbe),
    .evtDbe     (evtDbe),
    .evtDrop    (evtDrop),
    .evtAddr    (evtAddr),
    .rdData     (busRdData),
    .eccEnable  (eccEnable),
    .corrEnable (corrEnable),
    .injSbe     (injSbe),
    .injDbe     (injDbe),
    .irq        (irq),
    .statQ      (statQ),
    .sbeCnt     (sbeCnt),
    .dbeCnt     (dbeCnt),
    .errAddr    (errAddr)
  );

endmodule

// File: rtl/ecc_err_chk.sv
module ecc_err_chk
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int EA_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               clrBit,
  input logic [31:0]        busRdData,
  input logic               evtSbe,
  input logic               evtDbe,
  input logic               evtDrop,
  input logic               eccEnable,
  input logic               irq,
  input logic [NUM_EVT-1:0] statQ,
  input logic [CNT_W-1:0]   sbeCnt,
  input logic [CNT_W-1:0]   dbeCnt,
  input logic [EA_W-1:0]    errAddr
);

  logic intWr, clr, anyEvt, mapped;

  assign intWr  = busWrEn && (busAddr == ADDR_W'(OFF_INT));
  assign clr    = intWr && clrBit;
  assign anyEvt = eccEnable && (evtSbe || evtDbe || evtDrop);
  assign mapped = (busAddr == ADDR_W'(OFF_CTL))    || (busAddr == ADDR_W'(OFF_WIDTH))  ||
                  (busAddr == ADDR_W'(OFF_STAT))   || (busAddr == ADDR_W'(OFF_INT))    ||
                  (busAddr == ADDR_W'(OFF_SBECNT)) || (busAddr == ADDR_W'(OFF_DBECNT)) ||
                  (busAddr == ADDR_W'(OFF_ADDR));

  // R3
  sbe_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbeCnt == '1 && !clr) |=> (sbeCnt == '1));

  // R3
  dbe_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (dbeCnt >= $past(dbeCnt)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eccEnable && (evtSbe || evtDbe)) |=> $stable(errAddr));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(intWr || anyEvt));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !anyEvt) |=> (statQ == '0 && sbeCnt == '0 && dbeCnt == '0));

  // R7
  clear_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && eccEnable && evtSbe) |=> (sbeCnt == CNT_W'(1) && statQ[0]));

  // R8
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eccEnable && !clr) |=> ($stable(statQ) && $stable(sbeCnt) && $stable(dbeCnt)));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (busRdData == 32'd0));

endmodule

bind ecc_err_csr ecc_err_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EA_W(EA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .clrBit    (busWrData[4]),
  .busRdData (busRdData),
  .evtSbe    (evtSbe),
  .evtDbe    (evtDbe),
  .evtDrop   (evtDrop),
  .eccEnable (eccEnable),
  .irq       (irq),
  .statQ     (statQ),
  .sbeCnt    (sbeCnt),
  .dbeCnt    (dbeCnt),
  .errAddr   (errAddr)
);

// File: tb/sim_ecc_err_csr.sv
`timescale 1ns/1ps
module sim_ecc_err_csr;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        evtSbe = 1'b0, evtDbe = 1'b0, evtDrop = 1'b0;
  logic [31:0] evtAddr = '0;
  logic        eccEnable, corrEnable, injSbe, injDbe, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [31:0] mCtl;
  logic [2:0]  mStat;
  logic        mEn;
  logic [2:0]  mMask;
  logic [3:0]  mSbe, mDbe;
  logic [31:0] mAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_csr u0 (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evtSbe(evtSbe),
    .evtDbe(evtDbe), .evtDrop(evtDrop), .evtAddr(evtAddr),
    .eccEnable(eccEnable), .corrEnable(corrEnable), .injSbe(injSbe),
    .injDbe(injDbe), .irq(irq)
  );

  function automatic logic [3:0] satInc(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  function automatic logic expIrq();
    return mEn && |(mStat & ~mMask);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mCtl;
      8'h30: return 32'd40;
      8'h38: return {27'd0, mStat, 2'b00};
      8'h3C: return {28'd0, mMask, mEn};
      8'h40: return {28'd0, mSbe};
      8'h44: return {28'd0, mDbe};
      8'h48: return mAddr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model updates at posedge
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic s, input logic db, input logic dr, input logic [31:0] ea);
    logic eccOn;
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d;
    evtSbe = s; evtDbe = db; evtDrop = dr; evtAddr = ea;
    @(posedge clk);
    eccOn = mCtl[10];
    if (we && a == 8'h00) mCtl = d & 32'h0000_6C00;
    if (we && a == 8'h3C) begin
      mEn = d[0]; mMask = d[3:1];
      if (d[4]) begin mStat = '0; mSbe = '0; mDbe = '0; end
    end
    if (eccOn) begin
      mStat = mStat | {dr, db, s};
      if (s)  mSbe = satInc(mSbe);
      if (db) mDbe = satInc(mDbe);
      if (s || db) mAddr = ea;
    end
    #1;
    busWrEn = 1'b0; evtSbe = 1'b0; evtDbe = 1'b0; evtDrop = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic ev(input logic s, input logic db, input logic dr, input logic [31:0] ea);
    step(1'b0, 8'h00, 32'd0, s, db, dr, ea);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdData, expRead(a));
  endtask

  task automatic chkIrq(input string tag);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, expIrq()});
  endtask

  task automatic chkAll(input string tag);
    rd({tag, " ctl"},  8'h00);
    rd({tag, " stat"}, 8'h38);
    rd({tag, " int"},  8'h3C);
    rd({tag, " sbe"},  8'h40);
    rd({tag, " dbe"},  8'h44);
    rd({tag, " addr"}, 8'h48);
    chkIrq({tag, " irq"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    mCtl = '0; mStat = '0; mEn = 1'b0; mMask = '0; mSbe = '0; mDbe = '0; mAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    chkAll("R5 reset");
    check("R1 reset outputs", {28'd0, eccEnable, corrEnable, injSbe, injDbe}, 32'd0);

    // R1 control bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R1 ctl all ones", 8'h00);
    @(negedge clk);
    check("R1 outputs", {28'd0, eccEnable, corrEnable, injSbe, injDbe}, 32'hF);

    // R8 events ignored while checking is off
    wr(8'h00, 32'h0);
    wr(8'h3C, 32'h1);
    ev(1'b1, 1'b1, 1'b1, 32'hDEAD_0000);
    chkAll("R8 disabled");

    wr(8'h00, 32'h0000_0C00);
    // R2 R4 R5 first correctable error
    ev(1'b1, 1'b0, 1'b0, 32'h1000_0040);
    chkAll("R2 sbe");
    // R4 dropped alone keeps address
    ev(1'b0, 1'b0, 1'b1, 32'h2000_0080);
    chkAll("R4 drop");
    // R4 both kinds in one cycle
    ev(1'b1, 1'b1, 1'b0, 32'h3000_00C0);
    chkAll("R4 both");
    // R3 saturation
    for (int i = 0; i < 20; i++) ev(1'b1, 1'b0, 1'b0, 32'h4000_0000 + i);
    chkAll("R3 saturate");
    // R5 masks
    wr(8'h3C, 32'h0000_000F);
    chkAll("R5 masked");
    wr(8'h3C, 32'h0000_000B);
    chkAll("R5 dbe unmasked");
    // R6 clear with enable
    wr(8'h3C, 32'h0000_0011);
    chkAll("R6 clear+enable");
    ev(1'b0, 1'b1, 1'b0, 32'h5000_0000);
    chkAll("R6 enabled after clear");
    // R6 clear alone
    wr(8'h3C, 32'h0000_0010);
    ev(1'b1, 1'b0, 1'b0, 32'h6000_0000);
    chkAll("R6 clear alone");
    // R7 event on the clearing edge
    wr(8'h3C, 32'h1);
    ev(1'b1, 1'b1, 1'b0, 32'h7000_0000);
    step(1'b1, 8'h3C, 32'h11, 1'b1, 1'b0, 1'b0, 32'h7100_0000);
    chkAll("R7 clear vs event");
    // R10 read-only and unmapped
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h48, 32'h0);
    wr(8'h30, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    chkAll("R10 ro writes");
    rd("R10 unmapped 04", 8'h04);
    rd("R10 unmapped FC", 8'hFC);
    // R9 width
    rd("R9 width", 8'h30);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0)
        wr(8'h00, $urandom | (($urandom % 4 != 0) ? 32'h400 : 32'h0));
      else if (r == 1)
        wr(8'h3C, $urandom & ((($urandom % 3) == 0) ? 32'h1F : 32'h0F));
      else if (r == 2)
        step(1'b1, 8'h3C, ($urandom & 32'h0F) | 32'h10, $urandom % 2 == 0,
             $urandom % 2 == 0, $urandom % 2 == 0, $urandom);  // R7 random
      else
        ev($urandom % 3 == 0, $urandom % 5 == 0, $urandom % 7 == 0, $urandom);
      chkIrq("R5 random irq");
      if (n % 25 == 0) chkAll("R2 R3 R4 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule